// File: doc/BRIEF.md
# Polled Serial Slave Shifter with Timeout Abort

This block is the slave side of a synchronous serial link whose clock comes from an external master. It shifts a requested number of bits in both directions. The serial clock is not used as a clock. Its level is synchronized and then polled by a small state machine running on the system clock. For each bit the engine first puts the next transmit bit on the data-out pin. It then waits for the serial clock to reach its active level and captures the data-in pin at that moment. It then waits for the clock to return to its idle level before the next bit.

A separate timeout pin lets the surrounding logic cut a stalled transfer short. While either clock wait is still pending, a high level on that pin ends the transfer at once. The engine always reports how many bits actually completed, so a short transfer is visible to the caller. A mode input latched at start selects which clock level counts as active.

Top module: `sshift_slave`

## Requirements
- R1: After reset, busy, done, done_bits, rx_word and ser_dout are all 0.
- R2: Bits are sent most significant first over the low N bits of tx_word, where N is the accepted count. Bit tx_word[N-1] appears on ser_dout before the first active clock level. Each following bit appears only after the clock has returned to idle. ser_dout never changes while the block is idle.
- R3: On each active clock level, ser_din is captured into rx_word by shifting left and inserting at bit 0. After N bits, the first received bit sits at rx_word[N-1], and every bit above N-1 is 0.
- R4: With clk_inv=0 at the accepted start, the active level is high, so sampling is on the rising edge. With clk_inv=1, every tested level is reversed and sampling is on the falling edge.
- R5: A normal transfer ends after N bits with a one-cycle done pulse and done_bits equal to N.
- R6: If ser_tmo is high while the block waits for the active level, the transfer ends. done_bits equals the number of bits already captured, and rx_word holds those bits right-aligned with zeros above.
- R7: If ser_tmo is high while the block waits for the idle level, the transfer ends. done_bits includes the bit just captured in that clock phase.
- R8: A start with req_bits=0 gives done in the very next cycle with done_bits=0.
- R9: busy rises in the cycle after an accepted start and stays high through the done cycle. A start that arrives while busy is ignored, and it affects neither the count nor the data.
- R10: A req_bits value above MAX_BITS is treated as MAX_BITS.
- R11: rx_word and done_bits hold their values while idle until the next accepted start. This holds regardless of activity on the serial pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that polls the serial pins |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to begin a transfer |
| req_bits | input | CNT_W | Number of bits requested |
| clk_inv | input | 1 | 1 selects the low level as active (falling-edge sampling) |
| tx_word | input | MAX_BITS | Parallel transmit data, low N bits used |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| done_bits | output | CNT_W | Bits actually transferred |
| rx_word | output | MAX_BITS | Received bits, right-aligned |
| ser_clk | input | 1 | Serial clock from the external master |
| ser_din | input | 1 | Serial data in |
| ser_tmo | input | 1 | Timeout pin that aborts a pending clock wait |
| ser_dout | output | 1 | Serial data out |

## Verification
The bench drives a master model through every length from one to the word width, in both clock polarities. A design that took the wrong bit first, or sampled on the wrong edge, would show as a mismatched rx_word or a wrong bit on ser_dout.

It aborts in each of the two wait phases. A design that miscounted the bit captured in the current clock phase would report a count off by one. Other tests cover a zero-length request, an oversize request and a second start issued mid-transfer. A design with a bad clamp, a missing early completion or a restart on the second strobe would report the wrong length. The bench also toggles the serial pins while idle, which would expose results that are not held.

// File: rtl/sshift_pkg.sv
package sshift_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DRIVE,
        ST_WAIT_ACT,
        ST_WAIT_IDLE,
        ST_FINISH
    } sh_state_e;

    typedef struct packed {
        logic load;     // accept a new transfer
        logic drive;    // present next transmit bit
        logic capture;  // take the received bit
    } sh_ctl_t;

    // active level test, reversed when inv is set
    function automatic logic is_active(input logic lvl, input logic inv);
        return lvl ^ inv;
    endfunction

endpackage

// File: rtl/sshift_sync.sv
module sshift_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk) begin
            if (rst) chain <= '0;
            else     chain <= {chain[STAGES-2:0], d[i]};
        end
        assign q[i] = chain[STAGES-1];
    end
endmodule

// File: rtl/sshift_ctrl.sv
module sshift_ctrl
    import sshift_pkg::*;
#(
    parameter int MAX_BITS = 255,
    parameter int CNT_W    = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [CNT_W-1:0] req_bits,
    input  logic             clk_inv,
    input  logic             s_clk,
    input  logic             s_tmo,
    output sh_ctl_t          ctl,
    output logic [CNT_W-1:0] req_eff,
    output logic             busy,
    output logic             done,
    output logic [CNT_W-1:0] done_bits
);
    sh_state_e        state_q;
    logic             inv_q;
    logic [CNT_W-1:0] target_q;
    logic [CNT_W-1:0] bits_q;
    logic             act;

    assign req_eff = (int'(req_bits) > MAX_BITS) ? CNT_W'(MAX_BITS) : req_bits;
    assign act     = is_active(s_clk, inv_q);

    always_comb begin
        ctl.load    = (state_q == ST_IDLE) && start;
        ctl.drive   = (state_q == ST_DRIVE);
        ctl.capture = (state_q == ST_WAIT_ACT) && act;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            inv_q    <= 1'b0;
            target_q <= '0;
            bits_q   <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (start) begin
                    inv_q    <= clk_inv;
                    target_q <= req_eff;
                    bits_q   <= '0;
                    state_q  <= (req_eff == '0) ? ST_FINISH : ST_DRIVE;
                end
                ST_DRIVE: state_q <= ST_WAIT_ACT;
                ST_WAIT_ACT: begin
                    if (act) begin
                        bits_q  <= bits_q + 1'b1;
                        state_q <= ST_WAIT_IDLE;
                    end else if (s_tmo) begin
                        state_q <= ST_FINISH;
                    end
                end
                ST_WAIT_IDLE: begin
                    if (!act)
                        state_q <= (bits_q == target_q) ? ST_FINISH : ST_DRIVE;
                    else if (s_tmo)
                        state_q <= ST_FINISH;
                end
                ST_FINISH: state_q <= ST_IDLE;
                default:   state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy      = (state_q != ST_IDLE);
    assign done      = (state_q == ST_FINISH);
    assign done_bits = bits_q;
endmodule

// File: rtl/sshift_data.sv
module sshift_data
    import sshift_pkg::*;
#(
    parameter int MAX_BITS = 255,
    parameter int CNT_W    = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  sh_ctl_t             ctl,
    input  logic [CNT_W-1:0]    req_eff,
    input  logic [MAX_BITS-1:0] tx_word,
    input  logic                s_din,
    output logic                ser_dout,
    output logic [MAX_BITS-1:0] rx_word
);
    logic [MAX_BITS-1:0] tx_sh_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_sh_q  <= '0;
            rx_word  <= '0;
            ser_dout <= 1'b0;
        end else begin
            if (ctl.load) begin
                // align bit N-1 to the top so it leaves first
                tx_sh_q <= tx_word << (MAX_BITS - int'(req_eff));
                rx_word <= '0;
            end else if (ctl.drive) begin
                ser_dout <= tx_sh_q[MAX_BITS-1];
                tx_sh_q  <= tx_sh_q << 1;
            end
            if (ctl.capture)
                rx_word <= {rx_word[MAX_BITS-2:0], s_din};
        end
    end
endmodule

// File: rtl/sshift_slave.sv
module sshift_slave
    import sshift_pkg::*;
#(
    parameter int MAX_BITS = 255,
    localparam int CNT_W   = $clog2(MAX_BITS + 1)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic [CNT_W-1:0]    req_bits,
    input  logic                clk_inv,
    input  logic [MAX_BITS-1:0] tx_word,
    output logic                busy,
    output logic                done,
    output logic [CNT_W-1:0]    done_bits,
    output logic [MAX_BITS-1:0] rx_word,
    input  logic                ser_clk,
    input  logic                ser_din,
    input  logic                ser_tmo,
    output logic                ser_dout
);
    localparam int SYNC_W = 3;

    logic [SYNC_W-1:0] pins_s;
    sh_ctl_t           ctl;
    logic [CNT_W-1:0]  req_eff;

    sshift_sync #(.W(SYNC_W), .STAGES(2)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({ser_tmo, ser_din, ser_clk}),
        .q   (pins_s)
    );

    sshift_ctrl #(.MAX_BITS(MAX_BITS), .CNT_W(CNT_W)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .req_bits  (req_bits),
        .clk_inv   (clk_inv),
        .s_clk     (pins_s[0]),
        .s_tmo     (pins_s[2]),
        .ctl       (ctl),
        .req_eff   (req_eff),
        .busy      (busy),
        .done      (done),
        .done_bits (done_bits)
    );

    sshift_data #(.MAX_BITS(MAX_BITS), .CNT_W(CNT_W)) u_data (
        .clk      (clk),
        .rst      (rst),
        .ctl      (ctl),
        .req_eff  (req_eff),
        .tx_word  (tx_word),
        .s_din    (pins_s[1]),
        .ser_dout (ser_dout),
        .rx_word  (rx_word)
    );
endmodule

// File: rtl/sshift_slave_chk.sv
module sshift_slave_chk #(
    parameter int MAX_BITS = 255,
    parameter int CNT_W    = 8
) (
    input logic                clk,
    input logic                rst,
    input logic                start,
    input logic                busy,
    input logic                done,
    input logic [CNT_W-1:0]    done_bits,
    input logic [MAX_BITS-1:0] rx_word,
    input logic                ser_dout
);
    // R5
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R9
    done_busy_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> busy);

    // R9
    accept_chk: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);

    // R9
    busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !done) |=> busy);

    // R10
    cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (int'(done_bits) <= MAX_BITS));

    // R2
    dout_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |=> $stable(ser_dout));

    // R11
    result_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> ($stable(rx_word) && $stable(done_bits)));
endmodule

bind sshift_slave sshift_slave_chk #(.MAX_BITS(MAX_BITS), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .busy      (busy),
    .done      (done),
    .done_bits (done_bits),
    .rx_word   (rx_word),
    .ser_dout  (ser_dout)
);

// File: tb/sshift_slave_test.sv
module sshift_slave_test;
    localparam int CLK_P = 10;
    localparam int MB    = 8;
    localparam int CW    = 4;
    localparam int HOLD  = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [CW-1:0] req_bits = '0;
    logic          clk_inv = 1'b0;
    logic [MB-1:0] tx_word = '0;
    logic          busy, done, ser_dout;
    logic [CW-1:0] done_bits;
    logic [MB-1:0] rx_word;
    logic          ser_clk = 1'b0;
    logic          ser_din = 1'b0;
    logic          ser_tmo = 1'b0;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  reported = 0;

    sshift_slave #(.MAX_BITS(MB)) uut (
        .clk(clk), .rst(rst), .start(start), .req_bits(req_bits),
        .clk_inv(clk_inv), .tx_word(tx_word), .busy(busy), .done(done),
        .done_bits(done_bits), .rx_word(rx_word), .ser_clk(ser_clk),
        .ser_din(ser_din), .ser_tmo(ser_tmo), .ser_dout(ser_dout)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic report();
        if (!reported) begin
            reported = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    function automatic int mask(input int n);
        return (1 << n) - 1;
    endfunction

    task automatic idle_level(input bit inv);
        @(negedge clk);
        ser_clk = inv;
        cycles(4);
    endtask

    task automatic begin_xfer(input int n, input int tx, input bit inv);
        @(negedge clk);
        req_bits = CW'(n);
        tx_word  = MB'(tx);
        clk_inv  = inv;
        start    = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, "R9 busy after start", int'(busy), 1);
    endtask

    // one master bit: present din, sample dout, go active, go idle
    task automatic master_bit(input logic din, input bit inv, output logic dout_seen);
        ser_din = din;
        cycles(HOLD);
        dout_seen = ser_dout;
        ser_clk = ~inv;
        cycles(HOLD);
        ser_clk = inv;
    endtask

    task automatic wait_done(output bit got, output int cnt, output int rx);
        got = 0; cnt = -1; rx = -1;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (done) begin
                got = 1; cnt = int'(done_bits); rx = int'(rx_word);
                break;
            end
        end
    endtask

    task automatic full_xfer(input int nreq, input int neff, input int tx,
                             input int mw, input bit inv, input string tag);
        int   bad = 0;
        logic d;
        bit   got;
        int   cnt, rx;
        idle_level(inv);
        begin_xfer(nreq, tx, inv);
        for (int i = 0; i < neff; i++) begin
            master_bit(mw[neff-1-i], inv, d);
            if (d !== tx[neff-1-i]) bad++;
        end
        wait_done(got, cnt, rx);
        check(bad == 0, {tag, " R2 dout order"}, bad, 0);
        check(got, {tag, " R5 done seen"}, int'(got), 1);
        check(cnt == neff, {tag, " R5 count"}, cnt, neff);
        check(rx == (mw & mask(neff)), {tag, " R3 rx data"}, rx, mw & mask(neff));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        bit   got;
        int   cnt, rx;
        logic d;

        cycles(3);
        rst = 1'b0;
        @(negedge clk);
        // R1
        check(busy == 0 && done == 0, "R1 reset flags", int'({busy, done}), 0);
        check(done_bits == 0, "R1 reset count", int'(done_bits), 0);
        check(rx_word == 0 && ser_dout == 0, "R1 reset data", int'(rx_word), 0);

        // sweep lengths and both polarities (R4 in the inverted half)
        for (int inv = 0; inv < 2; inv++)
            for (int n = 1; n <= MB; n++)
                full_xfer(n, n, (8'hA5 ^ (n * 37)) & 8'hFF, (8'h3C + n * 11) & 8'hFF,
                          inv[0], inv ? "R4 inv" : "R4 norm");

        // R10 oversize requests clamp to MB
        full_xfer(12, MB, 8'h96, 8'h5B, 1'b0, "R10 req12");
        full_xfer(15, MB, 8'h71, 8'hE2, 1'b1, "R10 req15");

        // R8 zero-length request
        idle_level(1'b0);
        @(negedge clk);
        req_bits = '0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(done == 1'b1, "R8 immediate done", int'(done), 1);
        check(done_bits == 0, "R8 zero count", int'(done_bits), 0);

        // R6 abort while waiting for the active level
        for (int inv = 0; inv < 2; inv++) begin
            idle_level(inv[0]);
            begin_xfer(6, 8'h2D, inv[0]);
            master_bit(1'b1, inv[0], d);
            master_bit(1'b0, inv[0], d);
            master_bit(1'b1, inv[0], d);
            cycles(HOLD);
            ser_tmo = 1'b1;
            wait_done(got, cnt, rx);
            check(got && cnt == 3, "R6 abort count", cnt, 3);
            check(rx == 5, "R6 abort data", rx, 5);
            ser_tmo = 1'b0;
            cycles(4);
        end

        // R7 abort while waiting for the idle level
        for (int inv = 0; inv < 2; inv++) begin
            idle_level(inv[0]);
            begin_xfer(6, 8'h2D, inv[0]);
            master_bit(1'b1, inv[0], d);
            master_bit(1'b1, inv[0], d);
            ser_din = 1'b0;
            cycles(HOLD);
            ser_clk = ~inv[0];
            cycles(HOLD);
            ser_tmo = 1'b1;
            wait_done(got, cnt, rx);
            check(got && cnt == 3, "R7 abort count", cnt, 3);
            check(rx == 6, "R7 abort data", rx, 6);
            ser_tmo = 1'b0;
            ser_clk = inv[0];
            cycles(4);
        end

        // R9 start while busy is ignored
        idle_level(1'b0);
        begin_xfer(5, 8'h13, 1'b0);
        master_bit(1'b1, 1'b0, d);
        master_bit(1'b0, 1'b0, d);
        @(negedge clk);
        req_bits = CW'(2); tx_word = 8'hFF; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        master_bit(1'b1, 1'b0, d);
        check(d == 1'b0, "R9 dout unaffected", int'(d), 0);
        master_bit(1'b1, 1'b0, d);
        master_bit(1'b0, 1'b0, d);
        check(d == 1'b1, "R9 last dout", int'(d), 1);
        wait_done(got, cnt, rx);
        check(got && cnt == 5, "R9 count unaffected", cnt, 5);
        check(rx == 8'h16, "R9 data unaffected", rx, 8'h16);

        // R11 results hold while the pins move in idle
        for (int i = 0; i < 6; i++) begin
            ser_clk = ~ser_clk; ser_din = ~ser_din;
            ser_tmo = (i == 3);
            cycles(HOLD);
        end
        ser_tmo = 1'b0;
        check(done_bits == 5, "R11 count held", int'(done_bits), 5);
        check(rx_word == 8'h16, "R11 data held", int'(rx_word), 8'h16);
        check(busy == 0, "R11 stays idle", int'(busy), 0);

        report();
    end
endmodule